// File: doc/BRIEF.md
# Serial Port Register File Without Receive Buffering

This block models the programmer-visible register set of a classic PC-style serial controller that has no FIFO. A host bus addresses eight byte-wide registers through a 3-bit offset with separate read and write strobes; read data comes back one cycle after the read strobe. On the line side, received bytes enter through a valid/ready input, and transmitted bytes leave as a one-cycle valid pulse with data. There is no divisor latch, no baud generation and no bit framing: a byte written to the data register leaves at once, so the transmitter always reports itself empty.

Receive handling keeps one held byte that the host can read. A second line-side byte that arrives while the held byte is still unread waits in a one-entry slot. It moves into the held register when the host next reads data. While that slot is occupied, the line-side ready signal is low, so no byte is ever lost. Interrupt causes for receive and transmit are recorded in an identification register whose bit 0 is active-low, and the interrupt request output follows that bit. The scratch location reads back inverted, so software concludes that no scratch register is present. Modem status always reports carrier, data-set-ready and clear-to-send as present.

Offsets: 0 data, 1 interrupt enable, 2 identification (read) / FIFO control (write), 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.

Top module: `serial_regs`

## Requirements
- R1: After reset the identification register reads 0x01, `irq` is low, `rx_ready` is high, line status reads 0x60, and interrupt enable, line control, modem control and `fifo_ctl` read 0x00.
- R2: Bit 0 of the identification register reads 0 exactly while an interrupt cause is pending, and `irq` is high exactly when that bit is 0.
- R3: When a line-side byte is loaded into the held register, line status bit 0 becomes 1. If interrupt enable bit 0 is set, the identification register gains the receive cause (bits [2:1] = 2, i.e. bit 2) and its bit 0 clears.
- R4: A host write to offset 0 produces `tx_valid` high for exactly one cycle, with `tx_data` equal to the written byte, in the cycle after the write. If interrupt enable bit 1 is set, the identification register gains the transmit cause (bit 1) and its bit 0 clears.
- R5: A host read of offset 0 returns the held byte, zeroes the held byte, clears line status bit 0 and clears the receive cause. If the identification register then becomes zero, it is set to 0x01.
- R6: A host read of offset 0 with line status bit 0 clear returns the current held value and pulses `rx_underrun` together with `host_rvalid`.
- R7: A host read of offset 2 returns the identification value as it was before the read, and then clears the transmit cause; a zero result becomes 0x01. The receive cause is left unchanged.
- R8: A host write to offset 2 appears on `fifo_ctl` and leaves the identification register unchanged.
- R9: A line status read returns 0x60 ORed with the receive-ready bit (bit 0). Host writes to offsets 5 and 6 have no effect.
- R10: A modem status read always returns 0xB0 (bits 7, 5 and 4 set).
- R11: A scratch read returns the bitwise complement of the last byte written to offset 7 (0xFF after reset).
- R12: A line-side byte accepted while the held byte is unread does not overwrite it. It is stored in the one-entry slot, `rx_ready` stays low while the slot is full, and the next host data read loads it, setting line status bit 0 again and raising the receive cause again if it is enabled.
- R13: Interrupt enable, line control and modem control read back the last byte written to them.
- R14: `host_rdata` and `host_rvalid` are valid in the cycle after `host_rd`. A cycle that asserts both `host_wr` and `host_rd` is treated as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| rx_underrun | output | 1 | Pulses with read data when a data read found nothing ready |
| rx_valid | input | 1 | Line-side byte offered |
| rx_data | input | 8 | Line-side byte |
| rx_ready | output | 1 | Line side may offer a byte |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | 8 | Transmit byte |
| fifo_ctl | output | 8 | Last value written to the FIFO control offset |
| irq | output | 1 | Interrupt request, high while a cause is pending |

## Verification
Receive traffic is driven in three shapes. A single byte with receive interrupts disabled shows that the ready bit moves without touching the identification register. A single byte with interrupts enabled shows that the receive cause is raised and that reading the identification register does not clear it. Two back-to-back bytes show that the held byte is not overwritten, that `rx_ready` drops and that the waiting byte comes forward on the next read. Transmit writes with the enable off and then on separate the unconditional output pulse from the conditional cause. Enabling both causes at once checks that clearing one cause leaves the other pending and keeps `irq` high. Empty data reads, FIFO-control writes and writes to the status offsets check that those accesses have no side effects.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] offs_t;

  localparam offs_t OFF_DATA = 3'd0;
  localparam offs_t OFF_IEN  = 3'd1;
  localparam offs_t OFF_IDENT = 3'd2;
  localparam offs_t OFF_LCTL = 3'd3;
  localparam offs_t OFF_MCTL = 3'd4;
  localparam offs_t OFF_LSTAT = 3'd5;
  localparam offs_t OFF_MSTAT = 3'd6;
  localparam offs_t OFF_SCRATCH = 3'd7;

  // identification register fields
  localparam byte_t IDENT_IDLE  = 8'h01;
  localparam byte_t CAUSE_TX    = 8'h02;
  localparam byte_t CAUSE_RX    = 8'h04;

  // fixed status patterns
  localparam byte_t LSTAT_TX_IDLE = 8'h60;
  localparam byte_t MSTAT_FIXED   = 8'hB0;
endpackage

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
  import serial_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  offs_t wr_addr,
  input  byte_t wr_data,
  output byte_t ien_q,
  output byte_t lctl_q,
  output byte_t mctl_q,
  output byte_t fctl_q,
  output byte_t scr_q
);
  localparam int unsigned NREG = 5;
  localparam offs_t MAP [NREG] = '{OFF_IEN, OFF_LCTL, OFF_MCTL, OFF_IDENT, OFF_SCRATCH};

  byte_t regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (wr_en && wr_addr == MAP[g]) regs_q[g] <= wr_data;
    end
  end

  assign ien_q  = regs_q[0];
  assign lctl_q = regs_q[1];
  assign mctl_q = regs_q[2];
  assign fctl_q = regs_q[3];
  assign scr_q  = regs_q[4];
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
  import serial_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rx_valid,
  input  byte_t rx_data,
  output logic  rx_ready,
  input  logic  data_rd,
  output byte_t held_q,
  output logic  rdy_q,
  output logic  load_evt,
  output logic  empty_rd
);
  byte_t hold_n, slot_q, slot_n;
  logic  rdy_n, full_q, full_n;

  assign rx_ready = ~full_q;

  always_comb begin
    hold_n   = held_q;
    rdy_n    = rdy_q;
    slot_n   = slot_q;
    full_n   = full_q;
    load_evt = 1'b0;
    empty_rd = 1'b0;
    if (data_rd) begin
      if (rdy_q) begin
        hold_n = '0;
        rdy_n  = 1'b0;
      end else begin
        empty_rd = 1'b1;
      end
      if (full_q) begin
        hold_n   = slot_q;
        rdy_n    = 1'b1;
        full_n   = 1'b0;
        load_evt = 1'b1;
      end
    end
    if (rx_valid && !full_q) begin
      if (!rdy_n) begin
        hold_n   = rx_data;
        rdy_n    = 1'b1;
        load_evt = 1'b1;
      end else begin
        slot_n = rx_data;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      rdy_q  <= 1'b0;
      slot_q <= '0;
      full_q <= 1'b0;
    end else begin
      held_q <= hold_n;
      rdy_q  <= rdy_n;
      slot_q <= slot_n;
      full_q <= full_n;
    end
  end
endmodule

// File: rtl/serial_int_id.sv
module serial_int_id
  import serial_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ien,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic       ident_rd,
  input  logic       load_evt,
  output byte_t      ident_q
);
  byte_t ident_n;

  always_comb begin
    ident_n = ident_q;
    if (data_wr && ien[1]) begin
      ident_n    = ident_n | CAUSE_TX;
      ident_n[0] = 1'b0;
    end
    if (ident_rd) begin
      ident_n = ident_n & ~CAUSE_TX;
      if (ident_n == '0) ident_n = IDENT_IDLE;
    end
    if (data_rd) begin
      ident_n = ident_n & ~CAUSE_RX;
      if (ident_n == '0) ident_n = IDENT_IDLE;
    end
    if (load_evt && ien[0]) begin
      ident_n    = ident_n | CAUSE_RX;
      ident_n[0] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ident_q <= IDENT_IDLE;
    else     ident_q <= ident_n;
  end
endmodule

// File: rtl/serial_regs.sv
module serial_regs
  import serial_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rvalid,
  output logic       rx_underrun,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic [7:0] fifo_ctl,
  output logic       irq
);
  logic  rd_en, data_rd, data_wr, ident_rd;
  byte_t ien_q, lctl_q, mctl_q, scr_q, held_q, ident_q, rd_mux;
  logic  rdy_q, load_evt, empty_rd;

  assign rd_en    = host_rd & ~host_wr;
  assign data_rd  = rd_en && host_addr == OFF_DATA;
  assign ident_rd = rd_en && host_addr == OFF_IDENT;
  assign data_wr  = host_wr && host_addr == OFF_DATA;

  serial_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(host_wr), .wr_addr(host_addr), .wr_data(host_wdata),
    .ien_q(ien_q), .lctl_q(lctl_q), .mctl_q(mctl_q), .fctl_q(fifo_ctl), .scr_q(scr_q)
  );

  serial_rx_hold u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .data_rd(data_rd), .held_q(held_q), .rdy_q(rdy_q), .load_evt(load_evt),
    .empty_rd(empty_rd)
  );

  serial_int_id u_id (
    .clk(clk), .rst(rst), .ien(ien_q[1:0]), .data_wr(data_wr), .data_rd(data_rd),
    .ident_rd(ident_rd), .load_evt(load_evt), .ident_q(ident_q)
  );

  assign irq = ~ident_q[0];

  always_comb begin
    unique case (host_addr)
      OFF_DATA:    rd_mux = held_q;
      OFF_IEN:     rd_mux = ien_q;
      OFF_IDENT:   rd_mux = ident_q;
      OFF_LCTL:    rd_mux = lctl_q;
      OFF_MCTL:    rd_mux = mctl_q;
      OFF_LSTAT:   rd_mux = LSTAT_TX_IDLE | {7'b0, rdy_q};
      OFF_MSTAT:   rd_mux = MSTAT_FIXED;
      default:     rd_mux = ~scr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      rx_underrun <= 1'b0;
      tx_valid    <= 1'b0;
      tx_data     <= '0;
    end else begin
      host_rvalid <= rd_en;
      rx_underrun <= empty_rd;
      if (rd_en) host_rdata <= rd_mux;
      tx_valid <= data_wr;
      if (data_wr) tx_data <= host_wdata;
    end
  end
endmodule

// File: rtl/serial_regs_chk.sv
module serial_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] host_addr,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       irq
);
  logic [7:0] scr_shadow;
  logic       rd_only;
  assign rd_only = host_rd & ~host_wr;

  always_ff @(posedge clk) begin
    if (rst) scr_shadow <= 8'h00;
    else if (host_wr && host_addr == 3'd7) scr_shadow <= host_wdata;
  end

  a_r4_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_addr == 3'd0 |=> tx_valid && tx_data == $past(host_wdata));

  a_r12_ready_held: assert property (@(posedge clk) disable iff (rst)
    !rx_ready && !(rd_only && host_addr == 3'd0) |=> !rx_ready);

  a_r9_lstat_tx_idle: assert property (@(posedge clk) disable iff (rst)
    rd_only && host_addr == 3'd5 |=> host_rdata[6:5] == 2'b11);

  a_r10_mstat_fixed: assert property (@(posedge clk) disable iff (rst)
    rd_only && host_addr == 3'd6 |=> host_rdata == 8'hB0);

  a_r11_scratch_inv: assert property (@(posedge clk) disable iff (rst)
    rd_only && host_addr == 3'd7 |=> host_rdata == ~$past(scr_shadow));

  a_r2_ident_vs_irq: assert property (@(posedge clk) disable iff (rst)
    rd_only && host_addr == 3'd2 |=> host_rdata[0] == !$past(irq));
endmodule

bind serial_regs serial_regs_chk u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
);

// File: tb/sim_serial_regs.sv
`timescale 1ns/1ps
module sim_serial_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid, rx_underrun;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq;
  logic [7:0] tx_data, fifo_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_regs u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .rx_underrun(rx_underrun), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .fifo_ctl(fifo_ctl), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic und);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata; und = rx_underrun;
    check("R14 rvalid", {7'b0, host_rvalid}, 8'h01);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d; logic u;
    rd(a, d, u);
    check(req, d, exp);
  endtask

  task automatic rx_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rx_ready", {7'b0, rx_ready}, 8'h01);
    check("R1 fifo_ctl", fifo_ctl, 8'h00);
    rd_chk("R1 ident", 3'd2, 8'h01);
    rd_chk("R1 lstat", 3'd5, 8'h60);
    rd_chk("R1 ien", 3'd1, 8'h00);
    rd_chk("R1 lctl", 3'd3, 8'h00);
    rd_chk("R1 mctl", 3'd4, 8'h00);
    rd_chk("R11 scratch after reset", 3'd7, 8'hFF);
  endtask

  task automatic t_regs();
    wr(3'd3, 8'h83); rd_chk("R13 lctl", 3'd3, 8'h83);
    wr(3'd4, 8'h0B); rd_chk("R13 mctl", 3'd4, 8'h0B);
    wr(3'd1, 8'hF0); rd_chk("R13 ien", 3'd1, 8'hF0);
    wr(3'd7, 8'h5A); rd_chk("R11 scratch", 3'd7, 8'hA5);
    rd_chk("R10 mstat", 3'd6, 8'hB0);
    wr(3'd5, 8'hFF); wr(3'd6, 8'h00);
    rd_chk("R9 lstat after write", 3'd5, 8'h60);
    rd_chk("R10 mstat after write", 3'd6, 8'hB0);
    // simultaneous write and read is a write
    @(negedge clk);
    host_addr = 3'd3; host_wdata = 8'h1C; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    check("R14 wr wins rvalid", {7'b0, host_rvalid}, 8'h00);
    rd_chk("R14 wr wins value", 3'd3, 8'h1C);
  endtask

  task automatic t_tx();
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h41);
    check("R4 tx_valid", {7'b0, tx_valid}, 8'h01);
    check("R4 tx_data", tx_data, 8'h41);
    @(negedge clk);
    check("R4 tx pulse one cycle", {7'b0, tx_valid}, 8'h00);
    check("R4 no cause when disabled", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h42);
    check("R4 tx_data 2", tx_data, 8'h42);
    check("R2 irq on tx cause", {7'b0, irq}, 8'h01);
    rd_chk("R7 ident before clear", 3'd2, 8'h02);
    check("R2 irq after clear", {7'b0, irq}, 8'h00);
    rd_chk("R7 ident idle", 3'd2, 8'h01);
  endtask

  task automatic t_rx();
    logic [7:0] d; logic u;
    wr(3'd1, 8'h00);
    rx_send(8'h11);
    rd_chk("R3 lstat ready", 3'd5, 8'h61);
    rd_chk("R3 no cause when disabled", 3'd2, 8'h01);
    rd(3'd0, d, u);
    check("R5 data", d, 8'h11);
    check("R6 no underrun", {7'b0, u}, 8'h00);
    rd_chk("R5 lstat cleared", 3'd5, 8'h60);
    rd(3'd0, d, u);
    check("R6 empty read value", d, 8'h00);
    check("R6 underrun flag", {7'b0, u}, 8'h01);
    wr(3'd1, 8'h01);
    rx_send(8'h22);
    check("R3 irq", {7'b0, irq}, 8'h01);
    rd_chk("R3 ident rx cause", 3'd2, 8'h04);
    rd_chk("R7 rx cause kept", 3'd2, 8'h04);
    rd_chk("R5 data 2", 3'd0, 8'h22);
    check("R5 irq cleared", {7'b0, irq}, 8'h00);
    rd_chk("R5 ident idle", 3'd2, 8'h01);
  endtask

  task automatic t_pend();
    wr(3'd1, 8'h01);
    rx_send(8'h33);
    check("R12 ready after first", {7'b0, rx_ready}, 8'h01);
    rx_send(8'h44);
    check("R12 ready low when slot full", {7'b0, rx_ready}, 8'h00);
    rx_send(8'h55); // offered while not ready: not taken
    rd_chk("R12 first byte kept", 3'd0, 8'h33);
    check("R12 ready again", {7'b0, rx_ready}, 8'h01);
    check("R12 cause raised again", {7'b0, irq}, 8'h01);
    rd_chk("R12 lstat ready again", 3'd5, 8'h61);
    rd_chk("R12 second byte", 3'd0, 8'h44);
    rd_chk("R12 nothing left", 3'd5, 8'h60);
    check("R12 irq clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_fctl();
    wr(3'd2, 8'hC7);
    check("R8 fifo_ctl", fifo_ctl, 8'hC7);
    rd_chk("R8 ident unchanged", 3'd2, 8'h01);
  endtask

  task automatic t_both();
    wr(3'd1, 8'h03);
    rx_send(8'h66);
    wr(3'd0, 8'h77);
    rd_chk("R7 both causes", 3'd2, 8'h06);
    check("R2 irq still pending", {7'b0, irq}, 8'h01);
    rd_chk("R7 tx cleared rx kept", 3'd2, 8'h04);
    rd_chk("R5 data both", 3'd0, 8'h66);
    rd_chk("R5 ident idle both", 3'd2, 8'h01);
    check("R2 irq low", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_tx();
    t_rx();
    t_pend();
    t_fctl();
    t_both();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule